// File: doc/BRIEF.md
# Dual-Bus Register File

This block is a small register file whose four 8-bit entries sit between two shared data buses, A and B. Each bus has its own 2-bit register number, a load strobe and a drive strobe. In a single clock cycle the file can put one register on bus A and another register, or the same one, on bus B. In the same cycle it can capture the value on either bus into the register that bus addresses. Captures take effect on the rising clock edge. Placing a register on a bus is purely combinational.

Each bidirectional bus is split into three ports: an input byte, an output byte and an output enable. The enable stands for the tri-state control. While it is low, the output byte is held at zero, and an outer pad or bus wrapper treats the bus as released.

Each register has its own 2-to-1 input selector, which picks bus A or bus B as the source. It also has two driver enables, one per bus. Per-bus one-hot decoders generate all of these controls.

Top module: `dbus_regfile`

## Requirements
- R1: While `rstN` is low, all four registers are cleared to 0x00 asynchronously. After reset, driving any register on either bus shows 0x00.
- R2: When `aLoad` is 1 at a rising edge, the register numbered `aRegNum` takes the value of `aBusIn`. The new value is visible from the following cycle.
- R3: When `bLoad` is 1 at a rising edge, the register numbered `bRegNum` takes the value of `bBusIn`. This does not happen when R4 applies.
- R4: When `aLoad` and `bLoad` are both 1 and `aRegNum` equals `bRegNum`, the register takes `aBusIn`, so bus A has priority.
- R5: When `aLoad` and `bLoad` are both 1 and the two register numbers differ, both registers are written on the same edge.
- R6: When `aDrive` is 1, `aBusOe` is 1 and `aBusOut` equals register `aRegNum` in the same cycle. The B side works the same way with `bDrive`, `bRegNum`, `bBusOe` and `bBusOut`. Both buses can be driven in one cycle, from different registers or from the same register.
- R7: When a bus's drive strobe is 0, its output enable is 0 and its output byte is 0x00, whatever the loads and register numbers are.
- R8: A register that neither load addresses keeps its value across the edge.
- R9: A register that is driven and loaded in the same cycle shows its old value on the bus during that cycle.
- R10: The bus A output depends only on `aRegNum`, never on `bRegNum`. The bus B output depends only on `bRegNum`, never on `aRegNum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aRegNum | input | 2 | Register number used by bus A |
| bRegNum | input | 2 | Register number used by bus B |
| aLoad | input | 1 | Capture bus A into register `aRegNum` |
| bLoad | input | 1 | Capture bus B into register `bRegNum` |
| aDrive | input | 1 | Place register `aRegNum` on bus A |
| bDrive | input | 1 | Place register `bRegNum` on bus B |
| aBusIn | input | 8 | Value currently on bus A |
| bBusIn | input | 8 | Value currently on bus B |
| aBusOut | output | 8 | Value driven onto bus A (0 when released) |
| aBusOe | output | 1 | Bus A driver enable |
| bBusOut | output | 8 | Value driven onto bus B (0 when released) |
| bBusOe | output | 1 | Bus B driver enable |

## Verification
Drive results (R6, R7, R9, R10) are combinational. The bench applies stimulus just after the falling edge and samples two nanoseconds later, which is still before the next rising edge. Load results (R1 to R5, R8) become visible one cycle after the rising edge that captures them. The bench therefore reads them back through a drive strobe in the vector that follows the load. The checker's load properties compare the driven value with the bus input of the previous cycle, and they only do so when the register number has not changed.

// File: rtl/dbus_regfile_pkg.sv
package dbus_regfile_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_W     = 2;
  localparam int REG_COUNT = 1 << NUM_W;

  typedef logic [DATA_W-1:0] word_t;

  // Per-register strobes from control to datapath
  typedef struct packed {
    logic [REG_COUNT-1:0] loadEn;  // capture on next edge
    logic [REG_COUNT-1:0] srcIsA;  // 1: bus A is the source, 0: bus B
    logic [REG_COUNT-1:0] aDrvEn;  // driver onto bus A
    logic [REG_COUNT-1:0] bDrvEn;  // driver onto bus B
  } strobes_t;
endpackage

// File: rtl/dbus_regfile_dec.sv
module dbus_regfile_dec #(
  parameter int SEL_W = 2,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] num,
  output logic [LINES-1:0] oneHot
);
  for (genvar i = 0; i < LINES; i++) begin : gLine
    assign oneHot[i] = (num == SEL_W'(i));
  end
endmodule

// File: rtl/dbus_regfile_ctrl.sv
module dbus_regfile_ctrl
  import dbus_regfile_pkg::*;
(
  input  logic [NUM_W-1:0] aRegNum,
  input  logic [NUM_W-1:0] bRegNum,
  input  logic             aLoad,
  input  logic             bLoad,
  input  logic             aDrive,
  input  logic             bDrive,
  output strobes_t         strobes
);
  logic [REG_COUNT-1:0] aSel;
  logic [REG_COUNT-1:0] bSel;

  dbus_regfile_dec #(.SEL_W(NUM_W)) aDec (.num(aRegNum), .oneHot(aSel));
  dbus_regfile_dec #(.SEL_W(NUM_W)) bDec (.num(bRegNum), .oneHot(bSel));

  for (genvar i = 0; i < REG_COUNT; i++) begin : gGlue
    logic aHit;
    logic bHit;
    assign aHit = aLoad & aSel[i];
    assign bHit = bLoad & bSel[i];
    assign strobes.loadEn[i] = aHit | bHit;
    assign strobes.srcIsA[i] = aHit;          // A wins a shared target
    assign strobes.aDrvEn[i] = aDrive & aSel[i];
    assign strobes.bDrvEn[i] = bDrive & bSel[i];
  end
endmodule

// File: rtl/dbus_regfile_dp.sv
module dbus_regfile_dp
  import dbus_regfile_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strobes,
  input  word_t    aBusIn,
  input  word_t    bBusIn,
  output word_t    aBusOut,
  output logic     aBusOe,
  output word_t    bBusOut,
  output logic     bBusOe
);
  word_t regQ  [REG_COUNT];
  word_t aTerm [REG_COUNT];
  word_t bTerm [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : gReg
    word_t nextVal;
    assign nextVal = strobes.srcIsA[i] ? aBusIn : bBusIn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  regQ[i] <= '0;
      else if (strobes.loadEn[i]) regQ[i] <= nextVal;
    end

    // Per-register drivers: released drivers contribute zero
    assign aTerm[i] = strobes.aDrvEn[i] ? regQ[i] : '0;
    assign bTerm[i] = strobes.bDrvEn[i] ? regQ[i] : '0;
  end

  always_comb begin
    aBusOut = '0;
    bBusOut = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      aBusOut = aBusOut | aTerm[i];
      bBusOut = bBusOut | bTerm[i];
    end
  end

  assign aBusOe = |strobes.aDrvEn;
  assign bBusOe = |strobes.bDrvEn;
endmodule

// File: rtl/dbus_regfile.sv
module dbus_regfile
  import dbus_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] aRegNum,
  input  logic [1:0] bRegNum,
  input  logic       aLoad,
  input  logic       bLoad,
  input  logic       aDrive,
  input  logic       bDrive,
  input  logic [7:0] aBusIn,
  input  logic [7:0] bBusIn,
  output logic [7:0] aBusOut,
  output logic       aBusOe,
  output logic [7:0] bBusOut,
  output logic       bBusOe
);
  strobes_t strobes;

  dbus_regfile_ctrl ctrl (
    .aRegNum(aRegNum), .bRegNum(bRegNum),
    .aLoad(aLoad), .bLoad(bLoad),
    .aDrive(aDrive), .bDrive(bDrive),
    .strobes(strobes)
  );

  dbus_regfile_dp dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aBusIn(aBusIn), .bBusIn(bBusIn),
    .aBusOut(aBusOut), .aBusOe(aBusOe),
    .bBusOut(bBusOut), .bBusOe(bBusOe)
  );
endmodule

// File: rtl/dbus_regfile_chk.sv
module dbus_regfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] aRegNum,
  input logic [1:0] bRegNum,
  input logic       aLoad,
  input logic       bLoad,
  input logic       aDrive,
  input logic       bDrive,
  input logic [7:0] aBusIn,
  input logic [7:0] bBusIn,
  input logic [7:0] aBusOut,
  input logic       aBusOe,
  input logic [7:0] bBusOut,
  input logic       bBusOe
);
  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  AST_A_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !aDrive |-> (!aBusOe && aBusOut == 8'h00)); // R7
  AST_B_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !bDrive |-> (!bBusOe && bBusOut == 8'h00)); // R7
  AST_A_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    aDrive |-> aBusOe); // R6
  AST_B_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    bDrive |-> bBusOe); // R6
  AST_SHARED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (aDrive && bDrive && aRegNum == bRegNum) |-> aBusOut == bBusOut); // R6
  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (seen && aDrive && $past(aLoad) && aRegNum == $past(aRegNum))
      |-> aBusOut == $past(aBusIn)); // R2
  AST_B_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (seen && bDrive && $past(bLoad) && bRegNum == $past(bRegNum)
      && !($past(aLoad) && $past(aRegNum) == $past(bRegNum)))
      |-> bBusOut == $past(bBusIn)); // R3
  AST_A_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (seen && bDrive && $past(aLoad) && $past(bLoad)
      && $past(aRegNum) == $past(bRegNum) && bRegNum == $past(aRegNum))
      |-> bBusOut == $past(aBusIn)); // R4
endmodule

bind dbus_regfile dbus_regfile_chk chk (
  .clk(clk), .rstN(rstN), .aRegNum(aRegNum), .bRegNum(bRegNum),
  .aLoad(aLoad), .bLoad(bLoad), .aDrive(aDrive), .bDrive(bDrive),
  .aBusIn(aBusIn), .bBusIn(bBusIn), .aBusOut(aBusOut), .aBusOe(aBusOe),
  .bBusOut(bBusOut), .bBusOe(bBusOe)
);

// File: tb/dbus_regfile_test.sv
`timescale 1ns/1ps
module dbus_regfile_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] aRegNum = '0, bRegNum = '0;
  logic       aLoad = 1'b0, bLoad = 1'b0, aDrive = 1'b0, bDrive = 1'b0;
  logic [7:0] aBusIn = '0, bBusIn = '0;
  logic [7:0] aBusOut, bBusOut;
  logic       aBusOe, bBusOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dbus_regfile uut (
    .clk(clk), .rstN(rstN), .aRegNum(aRegNum), .bRegNum(bRegNum),
    .aLoad(aLoad), .bLoad(bLoad), .aDrive(aDrive), .bDrive(bDrive),
    .aBusIn(aBusIn), .bBusIn(bBusIn), .aBusOut(aBusOut), .aBusOe(aBusOe),
    .bBusOut(bBusOut), .bBusOe(bBusOe)
  );

  typedef struct packed {
    logic [3:0] req;
    logic aL, bL, aD, bD;
    logic [1:0] aN, bN;
    logic [7:0] aIn, bIn;
    logic expAOe;
    logic [7:0] expA;
    logic expBOe;
    logic [7:0] expB;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    //   req  aL bL aD bD aN bN  aIn    bIn    Aoe  A     Boe  B
    '{4'd9,  1,0,1,0, 0,0, 8'h11, 8'h00, 1, 8'h00, 0, 8'h00}, // R9 old value while loading
    '{4'd2,  0,1,1,0, 0,1, 8'h00, 8'h22, 1, 8'h11, 0, 8'h00}, // R2 readback; load B
    '{4'd3,  0,0,1,1, 1,0, 8'h00, 8'h00, 1, 8'h22, 1, 8'h11}, // R3 B-loaded read on A, R6 two reads
    '{4'd4,  1,1,0,1, 2,2, 8'h33, 8'h44, 0, 8'h00, 1, 8'h00}, // R4 set-up, shared target
    '{4'd4,  0,0,1,1, 2,2, 8'h00, 8'h00, 1, 8'h33, 1, 8'h33}, // R4 A wins, R6 same reg both
    '{4'd7,  1,1,0,0, 3,0, 8'h55, 8'h66, 0, 8'h00, 0, 8'h00}, // R7 released during loads
    '{4'd5,  0,0,1,1, 3,0, 8'h00, 8'h00, 1, 8'h55, 1, 8'h66}, // R5 both loads landed
    '{4'd8,  0,0,1,1, 1,2, 8'h00, 8'h00, 1, 8'h22, 1, 8'h33}, // R8 untouched regs kept
    '{4'd10, 0,0,1,0, 1,3, 8'h00, 8'h00, 1, 8'h22, 0, 8'h00}, // R10
    '{4'd10, 0,0,1,0, 1,0, 8'h00, 8'h00, 1, 8'h22, 0, 8'h00}  // R10 bRegNum moved
  };

  task automatic checkBus(input string tag, input logic oe, input logic [7:0] val,
                          input logic expOe, input logic [7:0] expVal);
    checks++;
    if (oe !== expOe || val !== expVal) begin
      errors++;
      $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
               tag, oe, val, expOe, expVal);
    end
  endtask

  task automatic idle();
    aLoad = 0; bLoad = 0; aDrive = 0; bDrive = 0;
    aBusIn = '0; bBusIn = '0;
  endtask

  // R1: read every register on both buses and expect zero
  task automatic checkAllZero(input string tag);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      idle();
      aDrive = 1; bDrive = 1; aRegNum = 2'(r); bRegNum = 2'(3 - r);
      #2;
      checkBus(tag, aBusOe, aBusOut, 1'b1, 8'h00);
      checkBus(tag, bBusOe, bBusOut, 1'b1, 8'h00);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2;
    checkBus("R7 after reset A", aBusOe, aBusOut, 1'b0, 8'h00);
    checkBus("R7 after reset B", bBusOe, bBusOut, 1'b0, 8'h00);
    checkAllZero("R1 reset");

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      aLoad = VECS[v].aL; bLoad = VECS[v].bL;
      aDrive = VECS[v].aD; bDrive = VECS[v].bD;
      aRegNum = VECS[v].aN; bRegNum = VECS[v].bN;
      aBusIn = VECS[v].aIn; bBusIn = VECS[v].bIn;
      #2;
      checkBus($sformatf("R%0d vec %0d bus A", VECS[v].req, v),
               aBusOe, aBusOut, VECS[v].expAOe, VECS[v].expA);
      checkBus($sformatf("R%0d vec %0d bus B", VECS[v].req, v),
               bBusOe, bBusOut, VECS[v].expBOe, VECS[v].expB);
    end

    // R3 and R8: B-side load of register 3 only; register 0 untouched
    @(negedge clk);
    idle(); bLoad = 1; bRegNum = 2'd3; bBusIn = 8'hA5; aRegNum = 2'd0;
    @(negedge clk);
    idle(); aDrive = 1; aRegNum = 2'd3; bDrive = 1; bRegNum = 2'd0;
    #2;
    checkBus("R3 B load read on A", aBusOe, aBusOut, 1'b1, 8'hA5);
    checkBus("R8 reg0 kept", bBusOe, bBusOut, 1'b1, 8'h66);

    // R1: asynchronous reset in the middle of operation
    @(negedge clk);
    idle();
    rstN = 1'b0;
    #1;
    aDrive = 1; aRegNum = 2'd3;
    #1;
    checkBus("R1 async clear", aBusOe, aBusOut, 1'b1, 8'h00);
    @(negedge clk) rstN = 1'b1;
    checkAllZero("R1 re-reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule